// File: doc/BRIEF.md
# DDR2 Bank Timing Tracker

This block sits inside a memory controller, beside the command scheduler of a four-bank DDR2-style device. On every rising clock edge it watches the command that goes out: activate, read, write, precharge of one bank, or precharge of all banks. A read or write may also request auto-precharge. For each bank it keeps the open/closed state and a set of down-counters for the row-timing minimums. From these it offers, per bank, a legal-now bit for activate, for read/write and for precharge. The scheduler uses these bits to pick the next command without breaking a row-timing rule.

It also turns the programmed CAS latency and additive latency into the read data latency. It derives the write data latency from that as one cycle less. A command that the tracker judges illegal is not applied to any bank state. Instead it sets a violation flag that stays set until reset, so a faulty scheduler is caught.

All four row-timing minimums are cycle-count parameters: activate-to-read/write, activate-to-precharge, precharge-to-activate and activate-to-activate. Each must be at least 2. The defaults match a 400 MHz clock at the fastest speed grade: 5, 18, 5 and 23 cycles.

Top module: `ddr2_bank_tracker`

## Requirements
- R1: After a synchronous active-low reset every bank is closed and no timer runs: `act_ok` is all ones, `rw_ok` is all zeros, `pre_ok` is all ones and `viol` is 0.
- R2: A read or write to a bank is legal from the edge that lies T_RCD cycles after that bank's activate edge, and never to a closed bank.
- R3: An explicit precharge of an open bank is legal no earlier than T_RAS cycles after that bank's activate edge.
- R4: Once a precharge has closed a bank, a new activate of that bank is legal no earlier than T_RP cycles after the precharge edge.
- R5: Two activates of one bank are at least T_RC cycles apart, even when T_RP has already elapsed. An activate of an open bank is never legal.
- R6: After a read or write, an explicit precharge of that bank waits at least AL + BL/2 cycles. `cfg_bl8`=1 selects burst length 8 (4 cycles) and 0 selects burst length 4 (2 cycles).
- R7: A read or write issued with `cmd_ap`=1 closes its bank without a further command. The close happens at the later of activate + T_RAS and read/write + AL + BL/2, and T_RP starts from that edge. While the close is pending, reads, writes and precharges to that bank are illegal.
- R8: An illegal command sets `viol` on the next edge. `viol` stays set until reset, and the command changes no bank state.
- R9: A precharge-all is legal only when a precharge is legal on every bank. It closes all banks and starts T_RP on every bank, idle ones included.
- R10: `rd_lat` equals `cfg_al` + `cfg_cl` and `wr_lat` equals that sum minus one. Both are registered, so they follow a configuration change one cycle later.
- R11: The banks are independent: commands to one bank never change the legal bits of another bank, except through precharge-all.
- R12: `cmd_op` encodes 0 no-op, 1 activate, 2 read, 3 write, 4 precharge of `cmd_bank`, 5 precharge-all. Codes 6 and 7, and any cycle with `cmd_valid` low, have no effect. A precharge of a closed bank is legal, changes nothing and does not restart T_RP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 3 | Command code (see R12) |
| cmd_bank | input | BW (2) | Target bank |
| cmd_ap | input | 1 | Auto-precharge request on read/write (address bit 10) |
| cfg_cl | input | CLW (3) | Programmed CAS latency, 3 to 6 |
| cfg_al | input | ALW (3) | Programmed additive latency |
| cfg_bl8 | input | 1 | 1: burst length 8, 0: burst length 4 |
| act_ok | output | NUM_BANKS (4) | Activate legal now, per bank |
| rw_ok | output | NUM_BANKS (4) | Read/write legal now, per bank |
| pre_ok | output | NUM_BANKS (4) | Precharge legal now, per bank |
| rd_lat | output | LW (4) | Read data latency in cycles |
| wr_lat | output | LW (4) | Write data latency in cycles |
| viol | output | 1 | Sticky illegal-command flag |

## Verification
The checker watches, on every cycle, the immediate consequences of a command. Just after an accepted activate, the same bank refuses read/write, precharge and another activate. An accepted precharge of an open bank blocks reactivation on the next cycle. An illegal activate raises `viol`, and `viol` never falls. The latencies follow the configuration one cycle later. Only the bench's scenarios can show the exact cycle at which each interval ends. The same holds for the auto-precharge close edge when either tRAS or the burst window dominates, and for the spread of a precharge-all onto idle banks. These scenarios also show that an illegal command leaves every bank unchanged and that banks do not disturb one another.

// File: rtl/ddr2_trk_pkg.sv
// Shared definitions for the DDR2 bank timing tracker.
// Assumes a 3-bit command code field at the block edge.
package ddr2_trk_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_PREA = 3'd5
    } trk_op_e;

endpackage

// File: rtl/ddr2_trk_issue.sv
// Command qualifier: decodes the sampled command, checks it against the
// per-bank legal bits and produces one-hot apply strobes, or an illegal pulse.
// Assumes cmd_bank < NB; codes 6 and 7 are treated as no-ops.
module ddr2_trk_issue
    import ddr2_trk_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = 2
) (
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [BW-1:0] cmd_bank,
    input  logic [NB-1:0] act_ok,
    input  logic [NB-1:0] rw_ok,
    input  logic [NB-1:0] pre_ok,
    output logic [NB-1:0] act_go,
    output logic [NB-1:0] rw_go,
    output logic [NB-1:0] pre_go,
    output logic          pre_all_go,
    output logic          illegal
);

    localparam logic [NB-1:0] ONE = {{(NB-1){1'b0}}, 1'b1};

    trk_op_e       op;
    logic [NB-1:0] sel;

    assign op  = trk_op_e'(cmd_op);
    assign sel = ONE << cmd_bank;

    // Qualify the command and route it to the addressed bank(s).
    always_comb begin
        act_go     = '0;
        rw_go      = '0;
        pre_go     = '0;
        pre_all_go = 1'b0;
        illegal    = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_ACT: begin
                    if (act_ok[cmd_bank]) act_go = sel;
                    else                  illegal = 1'b1;
                end
                OP_RD, OP_WR: begin
                    if (rw_ok[cmd_bank]) rw_go = sel;
                    else                 illegal = 1'b1;
                end
                OP_PRE: begin
                    if (pre_ok[cmd_bank]) pre_go = sel;
                    else                  illegal = 1'b1;
                end
                OP_PREA: begin
                    if (&pre_ok) pre_all_go = 1'b1;
                    else         illegal = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ddr2_trk_bank.sv
// One bank's row state and timing counters. Each counter is loaded with its
// minimum minus one on the starting edge and counts down to zero; a command
// is legal on the edge after the counter reaches zero.
// Assumes every T_* parameter is at least 2 and fits in CW bits, and that
// strobes arrive already qualified by ddr2_trk_issue.
module ddr2_trk_bank #(
    parameter int T_RCD = 5,
    parameter int T_RAS = 18,
    parameter int T_RP  = 5,
    parameter int T_RC  = 23,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_go,
    input  logic          rw_go,
    input  logic          rw_ap,
    input  logic          pre_go,
    input  logic          pre_all_go,
    input  logic [CW-1:0] xfer_len,
    output logic          act_ok,
    output logic          rw_ok,
    output logic          pre_ok
);

    localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] RAS_LD = CW'(T_RAS - 1);
    localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);
    localparam logic [CW-1:0] RC_LD  = CW'(T_RC - 1);

    logic          open_q;
    logic          ap_q;
    logic [CW-1:0] rcd_q;
    logic [CW-1:0] ras_q;
    logic [CW-1:0] rp_q;
    logic [CW-1:0] rc_q;
    logic [CW-1:0] xfer_q;
    logic          burst_done;
    logic          ap_close;
    logic          close_now;

    // Legal bits and close conditions from the current state.
    always_comb begin
        burst_done = (ras_q == '0) && (xfer_q == '0);
        ap_close   = open_q && ap_q && burst_done;
        close_now  = (pre_go && open_q) || pre_all_go || ap_close;
        act_ok     = !open_q && (rp_q == '0) && (rc_q == '0);
        rw_ok      = open_q && !ap_q && (rcd_q == '0);
        pre_ok     = !open_q || (!ap_q && burst_done);
    end

    // Row state and countdown timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            ap_q   <= 1'b0;
            rcd_q  <= '0;
            ras_q  <= '0;
            rp_q   <= '0;
            rc_q   <= '0;
            xfer_q <= '0;
        end else begin
            rcd_q  <= (rcd_q  == '0) ? '0 : rcd_q  - 1'b1;
            ras_q  <= (ras_q  == '0) ? '0 : ras_q  - 1'b1;
            rp_q   <= (rp_q   == '0) ? '0 : rp_q   - 1'b1;
            rc_q   <= (rc_q   == '0) ? '0 : rc_q   - 1'b1;
            xfer_q <= (xfer_q == '0) ? '0 : xfer_q - 1'b1;
            if (act_go) begin
                open_q <= 1'b1;
                rcd_q  <= RCD_LD;
                ras_q  <= RAS_LD;
                rc_q   <= RC_LD;
            end
            if (rw_go) begin
                xfer_q <= xfer_len - 1'b1;
                ap_q   <= rw_ap;
            end
            if (close_now) begin
                open_q <= 1'b0;
                ap_q   <= 1'b0;
                rp_q   <= RP_LD;
            end
        end
    end

endmodule

// File: rtl/ddr2_trk_latency.sv
// Registered data-latency calculator: read latency is additive plus CAS
// latency, write latency is one cycle less.
// Assumes cfg_cl >= 1 so that the write latency does not wrap.
module ddr2_trk_latency #(
    parameter int CLW = 3,
    parameter int ALW = 3,
    parameter int LW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CLW-1:0] cfg_cl,
    input  logic [ALW-1:0] cfg_al,
    output logic [LW-1:0]  rd_lat,
    output logic [LW-1:0]  wr_lat
);

    logic [LW-1:0] sum;

    // Posted-CAS read latency.
    always_comb sum = LW'(cfg_al) + LW'(cfg_cl);

    // Register both latencies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lat <= '0;
            wr_lat <= '0;
        end else begin
            rd_lat <= sum;
            wr_lat <= sum - 1'b1;
        end
    end

endmodule

// File: rtl/ddr2_bank_tracker.sv
// Top of the DDR2 bank timing tracker. Samples the issued command each
// rising edge, keeps per-bank row state and timers, reports per-bank legal
// bits, flags illegal commands stickily and computes data latencies.
// Assumes all T_* parameters >= 2 and commands driven by one scheduler.
module ddr2_bank_tracker #(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 5,
    parameter int T_RAS     = 18,
    parameter int T_RP      = 5,
    parameter int T_RC      = 23,
    parameter int CLW       = 3,
    parameter int ALW       = 3,
    parameter int BW        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int LW        = ((CLW > ALW) ? CLW : ALW) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [BW-1:0]        cmd_bank,
    input  logic                 cmd_ap,
    input  logic [CLW-1:0]       cfg_cl,
    input  logic [ALW-1:0]       cfg_al,
    input  logic                 cfg_bl8,
    output logic [NUM_BANKS-1:0] act_ok,
    output logic [NUM_BANKS-1:0] rw_ok,
    output logic [NUM_BANKS-1:0] pre_ok,
    output logic [LW-1:0]        rd_lat,
    output logic [LW-1:0]        wr_lat,
    output logic                 viol
);

    localparam int XMAX = (1 << ALW) - 1 + 4;
    localparam int TM1  = (T_RC > T_RAS) ? T_RC : T_RAS;
    localparam int TM2  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int TM3  = (TM1 > TM2) ? TM1 : TM2;
    localparam int TMAX = (TM3 > XMAX) ? TM3 : XMAX;
    localparam int CW   = $clog2(TMAX + 1);

    logic [NUM_BANKS-1:0] act_go;
    logic [NUM_BANKS-1:0] rw_go;
    logic [NUM_BANKS-1:0] pre_go;
    logic                 pre_all_go;
    logic                 illegal;
    logic [CW-1:0]        xfer_len;
    logic                 viol_q;

    // Burst window length: additive latency plus half the burst length.
    always_comb xfer_len = CW'(cfg_al) + (cfg_bl8 ? CW'(4) : CW'(2));

    ddr2_trk_issue #(
        .NB (NUM_BANKS),
        .BW (BW)
    ) u_issue (
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_bank   (cmd_bank),
        .act_ok     (act_ok),
        .rw_ok      (rw_ok),
        .pre_ok     (pre_ok),
        .act_go     (act_go),
        .rw_go      (rw_go),
        .pre_go     (pre_go),
        .pre_all_go (pre_all_go),
        .illegal    (illegal)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ddr2_trk_bank #(
            .T_RCD (T_RCD),
            .T_RAS (T_RAS),
            .T_RP  (T_RP),
            .T_RC  (T_RC),
            .CW    (CW)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_go     (act_go[b]),
            .rw_go      (rw_go[b]),
            .rw_ap      (cmd_ap),
            .pre_go     (pre_go[b]),
            .pre_all_go (pre_all_go),
            .xfer_len   (xfer_len),
            .act_ok     (act_ok[b]),
            .rw_ok      (rw_ok[b]),
            .pre_ok     (pre_ok[b])
        );
    end

    ddr2_trk_latency #(
        .CLW (CLW),
        .ALW (ALW),
        .LW  (LW)
    ) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_cl (cfg_cl),
        .cfg_al (cfg_al),
        .rd_lat (rd_lat),
        .wr_lat (wr_lat)
    );

    // Sticky violation flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       viol_q <= 1'b0;
        else if (illegal) viol_q <= 1'b1;
    end

    assign viol = viol_q;

endmodule

// File: rtl/ddr2_trk_checker.sv
// Property checker for ddr2_bank_tracker, attached by bind. Observes ports
// only. Assumes every T_* parameter of the tracker is at least 2.
module ddr2_trk_checker
    import ddr2_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BW        = 2,
    parameter int CLW       = 3,
    parameter int ALW       = 3,
    parameter int LW        = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_op,
    input logic [BW-1:0]        cmd_bank,
    input logic [CLW-1:0]       cfg_cl,
    input logic [ALW-1:0]       cfg_al,
    input logic [NUM_BANKS-1:0] act_ok,
    input logic [NUM_BANKS-1:0] rw_ok,
    input logic [NUM_BANKS-1:0] pre_ok,
    input logic [LW-1:0]        rd_lat,
    input logic [LW-1:0]        wr_lat,
    input logic                 viol
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        logic act_here;
        logic pre_here;
        assign act_here = cmd_valid && (cmd_op == OP_ACT) && (cmd_bank == BW'(b));
        assign pre_here = cmd_valid && (cmd_op == OP_PRE) && (cmd_bank == BW'(b));

        p_rcd_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (act_here && act_ok[b]) |=> !rw_ok[b]);

        p_ras_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (act_here && act_ok[b]) |=> !pre_ok[b]);

        p_rc_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (act_here && act_ok[b]) |=> !act_ok[b]);

        p_rp_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_here && pre_ok[b] && rw_ok[b]) |=> !act_ok[b]);

        p_viol_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (act_here && !act_ok[b]) |=> viol);
    end

    p_viol_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);

    p_rd_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(rd_lat) == int'($past(cfg_al)) + int'($past(cfg_cl))));

    p_wr_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(wr_lat) + 1 == int'(rd_lat)));

endmodule

bind ddr2_bank_tracker ddr2_trk_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BW        (BW),
    .CLW       (CLW),
    .ALW       (ALW),
    .LW        (LW)
) u_trk_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .cfg_cl    (cfg_cl),
    .cfg_al    (cfg_al),
    .act_ok    (act_ok),
    .rw_ok     (rw_ok),
    .pre_ok    (pre_ok),
    .rd_lat    (rd_lat),
    .wr_lat    (wr_lat),
    .viol      (viol)
);

// File: tb/ddr2_bank_tracker_bench.sv
// Self-checking bench: keeps per-bank timestamps of the last activate,
// precharge and read/write, and derives each legal bit arithmetically.
module ddr2_bank_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB    = 4;
    localparam int T_RCD = 3;
    localparam int T_RAS = 6;
    localparam int T_RP  = 2;
    localparam int T_RC  = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [1:0]    cmd_bank = 2'd0;
    logic          cmd_ap = 1'b0;
    logic [2:0]    cfg_cl = 3'd5;
    logic [2:0]    cfg_al = 3'd0;
    logic          cfg_bl8 = 1'b0;
    logic [NB-1:0] act_ok;
    logic [NB-1:0] rw_ok;
    logic [NB-1:0] pre_ok;
    logic [3:0]    rd_lat;
    logic [3:0]    wr_lat;
    logic          viol;

    ddr2_bank_tracker #(
        .NUM_BANKS (NB),
        .T_RCD     (T_RCD),
        .T_RAS     (T_RAS),
        .T_RP      (T_RP),
        .T_RC      (T_RC)
    ) u_ddr2_bank_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .cmd_ap    (cmd_ap),
        .cfg_cl    (cfg_cl),
        .cfg_al    (cfg_al),
        .cfg_bl8   (cfg_bl8),
        .act_ok    (act_ok),
        .rw_ok     (rw_ok),
        .pre_ok    (pre_ok),
        .rd_lat    (rd_lat),
        .wr_lat    (wr_lat),
        .viol      (viol)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int m_tact[NB];
    int m_tpre[NB];
    int m_trw[NB];
    int m_x[NB];
    bit m_open[NB];
    bit m_ap[NB];
    bit m_viol;

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, what, cyc, got, exp);
        end
    endtask

    function automatic int xlen();
        return int'(cfg_al) + (cfg_bl8 ? 4 : 2);
    endfunction

    function automatic int close_at(int b);
        int a = m_tact[b] + T_RAS;
        int r = m_trw[b] + m_x[b];
        return (a > r) ? a : r;
    endfunction

    function automatic bit exp_act(int b);
        int nx = cyc + 1;
        return !m_open[b] && (nx - m_tpre[b] >= T_RP) && (nx - m_tact[b] >= T_RC);
    endfunction

    function automatic bit exp_rw(int b);
        return m_open[b] && !m_ap[b] && (cyc + 1 - m_tact[b] >= T_RCD);
    endfunction

    function automatic bit exp_pre(int b);
        int nx = cyc + 1;
        return !m_open[b] ||
               (!m_ap[b] && (nx - m_tact[b] >= T_RAS) && (nx - m_trw[b] >= m_x[b]));
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_tact[b] = -1000; m_tpre[b] = -1000; m_trw[b] = -1000;
            m_x[b] = 2; m_open[b] = 0; m_ap[b] = 0;
        end
        m_viol = 0;
    endtask

    // One clock: advance the edge count, apply auto-precharge closes, sample at negedge.
    task automatic step();
        @(posedge clk);
        cyc++;
        for (int b = 0; b < NB; b++) begin
            if (m_ap[b] && cyc == close_at(b)) begin
                m_open[b] = 0; m_ap[b] = 0; m_tpre[b] = cyc;
            end
        end
        @(negedge clk);
    endtask

    task automatic check_banks(string tag);
        for (int b = 0; b < NB; b++) begin
            chk(tag, $sformatf("act_ok[%0d] (R5)", b), int'(act_ok[b]), int'(exp_act(b)));
            chk(tag, $sformatf("rw_ok[%0d] (R2)", b), int'(rw_ok[b]), int'(exp_rw(b)));
            chk(tag, $sformatf("pre_ok[%0d] (R3)", b), int'(pre_ok[b]), int'(exp_pre(b)));
        end
        chk(tag, "viol (R8)", int'(viol), int'(m_viol));
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            step();
            check_banks(tag);
        end
    endtask

    task automatic issue(bit v, int op, int b, bit ap);
        bit legal = 0;
        int x = xlen();
        if (v) begin
            case (op)
                1: legal = exp_act(b);
                2, 3: legal = exp_rw(b);
                4: legal = exp_pre(b);
                5: begin
                    legal = 1;
                    for (int k = 0; k < NB; k++) if (!exp_pre(k)) legal = 0;
                end
                default: legal = 0;
            endcase
        end
        cmd_valid = v; cmd_op = 3'(op); cmd_bank = 2'(b); cmd_ap = ap;
        step();
        cmd_valid = 0; cmd_op = 3'd0; cmd_ap = 0;
        if (v && op >= 1 && op <= 5) begin
            if (!legal) m_viol = 1;
            else begin
                case (op)
                    1: begin m_open[b] = 1; m_tact[b] = cyc; end
                    2, 3: begin m_trw[b] = cyc; m_x[b] = x; m_ap[b] = ap; end
                    4: if (m_open[b]) begin m_open[b] = 0; m_tpre[b] = cyc; end
                    default: for (int k = 0; k < NB; k++) begin
                        m_open[k] = 0; m_tpre[k] = cyc;
                    end
                endcase
            end
        end
        check_banks("issue");
    endtask

    task automatic wait_rw(int b, string tag);
        for (int i = 0; i < 64 && !exp_rw(b); i++) run(1, tag);
    endtask

    task automatic wait_pre(int b, string tag);
        for (int i = 0; i < 64 && !exp_pre(b); i++) run(1, tag);
    endtask

    task automatic wait_act(int b, string tag);
        for (int i = 0; i < 64 && !exp_act(b); i++) run(1, tag);
    endtask

    task automatic do_reset();
        rst_n = 0; cmd_valid = 0;
        step(); step();
        rst_n = 1;
        model_reset();
        check_banks("R1");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++; checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        chk("R1", "act_ok", int'(act_ok), 15);
        chk("R1", "rw_ok", int'(rw_ok), 0);
        chk("R1", "pre_ok", int'(pre_ok), 15);
        chk("R1", "viol", int'(viol), 0);

        // R2 R3 R5: full interval sweep after one activate.
        issue(1, 1, 0, 0);
        run(T_RC + 2, "R2");
        issue(1, 4, 0, 0);
        run(T_RP + 2, "R4");

        // R5: precharge at tRAS, tRC dominates reactivation.
        issue(1, 1, 1, 0);
        wait_pre(1, "R3");
        issue(1, 4, 1, 0);
        wait_act(1, "R5");
        chk("R5", "activate edge - previous activate", cyc + 1 - m_tact[1], T_RC);
        // R4: late precharge, tRP dominates.
        issue(1, 1, 1, 0);
        run(T_RC + 1, "R4");
        issue(1, 4, 1, 0);
        wait_act(1, "R4");
        chk("R4", "activate edge - precharge edge", cyc + 1 - m_tpre[1], T_RP);

        // R6: burst window over burst lengths and additive latencies.
        for (int bl = 0; bl < 2; bl++) begin
            for (int al = 0; al <= 5; al += 5) begin
                cfg_bl8 = bl[0]; cfg_al = 3'(al);
                wait_act(2, "R6");
                issue(1, 1, 2, 0);
                wait_rw(2, "R6");
                run(1, "R6");
                issue(1, (al == 0) ? 2 : 3, 2, 0);
                wait_pre(2, "R6");
                chk("R6", "precharge edge - read/write edge", cyc + 1 - m_trw[2],
                    int'(cfg_al) + (bl == 1 ? 4 : 2));
                issue(1, 4, 2, 0);
            end
        end

        // R7: auto-precharge, tRAS dominant then burst dominant.
        cfg_al = 3'd0; cfg_bl8 = 0;
        wait_act(3, "R7");
        issue(1, 1, 3, 0);
        wait_rw(3, "R7");
        issue(1, 3, 3, 1);
        run(T_RAS + T_RP + 2, "R7");
        cfg_al = 3'd5; cfg_bl8 = 1;
        wait_act(3, "R7");
        issue(1, 1, 3, 0);
        wait_rw(3, "R7");
        issue(1, 2, 3, 1);
        run(12, "R7");
        chk("R7", "bank reopenable", int'(act_ok[3]), 1);

        // R11: staggered activates on all banks, then R9 precharge-all.
        cfg_al = 3'd0; cfg_bl8 = 0;
        for (int b = 0; b < NB; b++) wait_act(b, "R11");
        issue(1, 1, 0, 0);
        run(1, "R11");
        issue(1, 1, 1, 0);
        issue(1, 1, 2, 0);
        run(2, "R11");
        issue(1, 1, 3, 0);
        for (int b = 0; b < NB; b++) wait_pre(b, "R9");
        issue(1, 5, 0, 0);
        chk("R9", "act_ok after precharge-all", int'(act_ok), 0);
        run(T_RC, "R9");
        issue(1, 5, 0, 0);
        chk("R9", "idle banks restart tRP", int'(act_ok), 0);
        run(T_RP + 1, "R9");

        // R12: no-effect encodings.
        issue(0, 1, 0, 0);
        chk("R12", "valid low leaves bank 0 closed", int'(rw_ok[0]), 0);
        issue(1, 6, 1, 0);
        issue(1, 7, 2, 0);
        issue(1, 0, 3, 0);
        chk("R12", "no viol from codes 0/6/7", int'(viol), 0);
        issue(1, 4, 1, 0);
        chk("R12", "precharge of closed bank keeps act_ok", int'(act_ok[1]), 1);
        run(2, "R12");

        // R8: each illegal kind, state unchanged, then reset clears.
        issue(1, 1, 0, 0);
        issue(1, 2, 0, 0);
        chk("R8", "early read sets viol", int'(viol), 1);
        run(T_RCD + 1, "R8");
        issue(1, 1, 0, 0);
        issue(1, 4, 0, 0);
        run(T_RAS, "R8");
        do_reset();
        issue(1, 3, 2, 0);
        chk("R8", "write to closed bank sets viol", int'(viol), 1);
        run(3, "R8");
        do_reset();
        issue(1, 1, 1, 0);
        wait_rw(1, "R8");
        issue(1, 2, 1, 1);
        issue(1, 5, 0, 0);
        issue(1, 3, 1, 0);
        chk("R8", "commands during pending close set viol", int'(viol), 1);
        run(T_RAS + T_RP, "R8");
        do_reset();

        // R10: latency sweep.
        for (int cl = 3; cl <= 6; cl++) begin
            for (int al = 0; al <= 5; al++) begin
                cfg_cl = 3'(cl); cfg_al = 3'(al);
                step();
                chk("R10", "rd_lat", int'(rd_lat), al + cl);
                chk("R10", "wr_lat", int'(wr_lat), al + cl - 1);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule